// File: doc/BRIEF.md
# One-Hot Subcycle Timing Generator

This block splits every instruction cycle of a small 4-bit processor core into eight subcycles. It runs on a fast system clock. It watches two non-overlapping phase strobes, which are themselves registered signals in that clock domain. It keeps an eight-stage one-hot ring that moves on by one position for each activation of the first phase strobe.

The ring needs no external load to start. After reset it holds all zeros. Whenever it holds a pattern that is not one-hot, the next phase-one activation puts it into subcycle 0. A cycle-boundary marker is raised during the last subcycle. Companion devices use this marker to line up their own subcycle counters, because the subcycle after it always begins a new instruction cycle.

Top module: `subcycle_timer`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the ring is cleared: after that clock edge `subcycle_o` is all zeros and `sync_o` is low.
- R2: When the ring is not one-hot (all zeros, or more than one bit set), the next step loads subcycle 0, which is bit 0 of `subcycle_o` (value 8'b0000_0001).
- R3: A step happens on the first system-clock edge at which `ph1_i` is sampled high after being sampled low at the previous edge. `subcycle_o` changes at that same edge. A pulse gives exactly one step however many cycles it stays high.
- R4: Each step moves the set bit from position i to position i+1, and from bit 7 back to bit 0.
- R5: A rising `ph1_i` seen while `ph2_i` is high (overlapping phases) is ignored. No step occurs, including in later cycles of that same `ph1_i` pulse.
- R6: Without a step, `subcycle_o` and `sync_o` hold their values, whatever level `ph1_i` or `ph2_i` has.
- R7: `sync_o` is high exactly while bit 7 (subcycle 7) is set, so it appears once every eight steps.
- R8: After the first step following reset, `subcycle_o` has exactly one bit set on every cycle until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| ph1_i | input | 1 | Registered phase-one strobe; its activation advances the ring |
| ph2_i | input | 1 | Registered phase-two strobe; blocks a step when it overlaps phase one |
| subcycle_o | output | 8 | One-hot subcycle vector, bit i = subcycle i |
| sync_o | output | 1 | Cycle-boundary marker, high during the last subcycle |

## Verification
Each result is due at the first rising edge at which the bench's new `ph1_i` level is seen. The bench therefore drives inputs on the falling edge and samples `subcycle_o` and `sync_o` at the next falling edge, half a period after the step. On every later cycle of a long pulse, and during low gaps, it checks again at falling edges that nothing moved. Reset results are checked one falling edge after the reset edge. The count of `sync_o` rises is compared with the number of steps divided by eight.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
  // Number of subcycles in one instruction cycle.
  localparam int unsigned SUBCYCLES_DEF = 8;
  // Subcycle during which the boundary marker is raised.
  localparam int unsigned SYNC_SUB_DEF  = SUBCYCLES_DEF - 1;

  // Index that follows idx in a ring of n positions.
  function automatic int unsigned ring_next_index(input int unsigned idx,
                                                  input int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/tmg_phase_edge.sv
module tmg_phase_edge (
  input  logic clk,
  input  logic rst,
  input  logic ph1,
  input  logic ph2,
  output logic step
);
  logic ph1_seen_q;

  // Tracks the previous sample even in reset, so a pulse that spans reset release is not counted.
  always_ff @(posedge clk) begin
    ph1_seen_q <= ph1;
  end

  logic ph1_rise;
  assign ph1_rise = ph1 & ~ph1_seen_q;
  assign step     = ph1_rise & ~ph2;

  AST_ONE_STEP_PER_PULSE: assert property (@(posedge clk) disable iff (rst)
    step |=> !step); // R3
  AST_OVERLAP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    ph2 |-> !step); // R5
endmodule

// File: rtl/tmg_ring.sv
module tmg_ring #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [N-1:0] state
);
  localparam int unsigned LAST = N - 1;

  function automatic logic is_onehot(input logic [N-1:0] v);
    int unsigned cnt;
    cnt = 0;
    for (int i = 0; i < N; i++) cnt += v[i] ? 1 : 0;
    return cnt == 1;
  endfunction

  function automatic logic [N-1:0] rotate_up(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]};
  endfunction

  logic         legal;
  logic [N-1:0] next_state;

  assign legal      = is_onehot(state);
  assign next_state = legal ? rotate_up(state) : {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       state <= '0;
    else if (step) state <= next_state;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state == '0)); // R1
  AST_REPAIR_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step && $countones(state) != 1) |=> state[0]); // R2
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && state[LAST]) |=> state[0]); // R4
  AST_ADVANCE_LOW: assert property (@(posedge clk) disable iff (rst)
    (step && state[0]) |=> state[1]); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state)); // R6
  AST_ONEHOT_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> ($countones(state) == 1)); // R8
endmodule

// File: rtl/tmg_sync_mark.sv
module tmg_sync_mark #(
  parameter int unsigned N        = 8,
  parameter int unsigned SYNC_SUB = N - 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] state,
  output logic         sync
);
  generate
    if (SYNC_SUB < N) begin : g_mark
      assign sync = state[SYNC_SUB];
    end else begin : g_none
      assign sync = 1'b0;
    end
  endgenerate

  AST_SYNC_AFTER_RESET: assert property (@(posedge clk)
    rst |=> !sync); // R1
  AST_SYNC_ONEHOT_PEER: assert property (@(posedge clk) disable iff (rst)
    sync |-> ($countones(state) == 1)); // R7
endmodule

// File: rtl/subcycle_timer.sv
module subcycle_timer #(
  parameter int unsigned SUBCYCLES = tmg_pkg::SUBCYCLES_DEF,
  parameter int unsigned SYNC_SUB  = SUBCYCLES - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ph1_i,
  input  logic                 ph2_i,
  output logic [SUBCYCLES-1:0] subcycle_o,
  output logic                 sync_o
);
  logic step;

  tmg_phase_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .ph1  (ph1_i),
    .ph2  (ph2_i),
    .step (step)
  );

  tmg_ring #(.N(SUBCYCLES)) u_ring (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .state (subcycle_o)
  );

  tmg_sync_mark #(.N(SUBCYCLES), .SYNC_SUB(SYNC_SUB)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .state (subcycle_o),
    .sync  (sync_o)
  );

  AST_SYNC_ROSE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> $past(step)); // R7
  AST_OUT_STABLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sync_o)); // R6
endmodule

// File: tb/tb_subcycle_timer.sv
module tb_subcycle_timer;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ph1 = 1'b0;
  logic         ph2 = 1'b0;
  logic [N-1:0] sub;
  logic         sync;

  int checks = 0;
  int errors = 0;
  int exp_idx = 0;
  bit exp_valid = 0;
  int sync_rises = 0;
  int steps_done = 0;

  always #4 clk = ~clk;

  subcycle_timer dut (
    .clk(clk), .rst(rst), .ph1_i(ph1), .ph2_i(ph2),
    .subcycle_o(sub), .sync_o(sync)
  );

  function automatic logic [N-1:0] exp_vec();
    return exp_valid ? (N'(1) << exp_idx) : '0;
  endfunction

  task automatic check(input string tag);
    logic [N-1:0] ev;
    logic         es;
    ev = exp_vec();
    es = exp_valid && (exp_idx == N - 1);
    checks++;
    if (sub !== ev || sync !== es) begin
      errors++;
      $display("FAIL %s: sub=%b sync=%b expected sub=%b sync=%b", tag, sub, sync, ev, es);
    end
  endtask

  // One phase-one pulse: high for hi cycles, low for lo cycles; ph2 held at blk during the rise.
  task automatic pulse(input int hi, input int lo, input bit blk, input string tag);
    logic prev_sync;
    prev_sync = sync;
    @(negedge clk);
    ph1 = 1'b1;
    ph2 = blk;
    @(negedge clk);
    if (!blk) begin
      if (!exp_valid) begin exp_valid = 1; exp_idx = 0; end
      else exp_idx = (exp_idx + 1) % N;
      steps_done++;
    end
    check(tag);
    if (sync && !prev_sync) sync_rises++;
    ph2 = 1'b0;
    for (int k = 1; k < hi; k++) begin
      @(negedge clk);
      check("R3/R5 hold while ph1 stays high");
    end
    ph1 = 1'b0;
    for (int k = 0; k < lo; k++) begin
      if (k == 1) ph2 = 1'b1;
      @(negedge clk);
      check("R6 hold while ph1 low");
    end
    ph2 = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst = 1'b0;
    @(negedge clk);
    check("R6 idle after reset");
    // First step from the all-zero ring: subcycle 0.
    pulse(1, 1, 0, "R2 self-start loads bit 0");
    // Sweep pulse widths and gaps over three full rings.
    for (int p = 0; p < 3 * N - 1; p++) begin
      pulse(1 + (p % 4), 1 + ((p / 4) % 3), 0, "R4 advance order");
      checks++;
      if ($countones(sub) != 1) begin
        errors++;
        $display("FAIL R8: ones=%0d expected 1", $countones(sub));
      end
    end
    // 24 steps counted from subcycle 0: the boundary marker was seen three times.
    checks++;
    if (sync_rises != 3) begin
      errors++;
      $display("FAIL R7: sync rises=%0d expected 3", sync_rises);
    end
    // Overlapping phases ignored, at several ring positions.
    for (int p = 0; p < N; p++) begin
      pulse(3, 2, 1, "R5 overlap ignored");
      pulse(2, 1, 0, "R4 step after overlap");
    end
    // Reset mid-cycle, then self-start again.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    exp_valid = 0;
    exp_idx = 0;
    check("R1 reset mid-cycle");
    rst = 1'b0;
    pulse(2, 2, 0, "R2 restart at bit 0");
    for (int p = 0; p < N; p++) pulse(1, 1, 0, "R4 wrap after restart");
    check("R4 back at bit 0 after full ring");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule